// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block buffers received characters between a serial deserializer and a host in a 16550-style serial port. Every character enters with three error tags (break, framing and parity) stored next to it. The tags appear in the line status byte only while their character sits at the head of the queue. The host drains characters with a data-read strobe and reads the line status byte with a status-read strobe. Reading the status byte clears the overrun flag and the head character's tags.

The block also holds the queue-control fields the host writes: queue enable, receive flush, transmit flush, DMA mode and trigger code. With the enable bit clear the block is in character mode, and the store holds one character. With it set the block is in queue mode, and the store holds `DEPTH` characters. A mode register with two states, `MODE_CHAR` and `MODE_FIFO`, follows the enable bit. The transition `MODE_CHAR -> MODE_FIFO` happens on a control write with bit 0 = 1. The transition `MODE_FIFO -> MODE_CHAR` happens on a control write with bit 0 = 0. Both transitions flush the receive store. A write with bit 0 = 0 while already in `MODE_CHAR` keeps the state and also flushes.

Top module: `rx_fifo_tagged`

## Requirements
- R1: After reset the block is in character mode with DMA mode 0, trigger code 00, an empty store, a line status byte of 0x00 and no transmit flush pulse.
- R2: A control write with bit 0 = 1 selects queue mode and loads DMA mode from bit 3 and the trigger code from bits 7:6. A control write with bit 0 = 0 selects character mode, empties the receive store and leaves DMA mode and the trigger code unchanged, ignoring bits 1, 2, 3, 6 and 7.
- R3: A control write with bit 0 = 1 empties the receive store when bit 1 = 1 or when the block was in character mode. `tx_fifo_clr` is high for exactly the cycle after any write that has bit 0 = 0, or bit 0 = 1 with bit 2 = 1, or that enters queue mode. Neither flush persists to later writes.
- R4: The store keeps arrival order. It holds up to `DEPTH` characters in queue mode and 1 in character mode. `rx_level` gives the count, and `rd_data` shows the head character whenever the count is non-zero.
- R5: A character that arrives when the count equals the capacity is discarded and sets line status bit 1 (overrun), even if a data read occurs in the same cycle.
- R6: Line status bit 0 (data ready) is 1 exactly when the count is non-zero.
- R7: Line status bits 4, 3 and 2 show the head character's break, framing and parity tags respectively. They read 0 when the store is empty. Tags of characters behind the head are not visible there.
- R8: A status read clears the overrun flag, unless a character is discarded in the same cycle. It also clears the head character's three tags, unless that character is popped in the same cycle.
- R9: Line status bit 7 is 1 in queue mode while any held character still carries a tag, and is always 0 in character mode.
- R10: `trig_hit` is 1 when the count is at least the trigger level. In queue mode, codes 00, 01, 10 and 11 select levels of 1, 4, 8 and 14. In character mode the level is 1.
- R11: Line status bits 6 and 5 read 0; the transmit side supplies them.
- R12: A receive flush takes priority over a character arriving in the same cycle. That character is discarded without setting overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fcr_we | input | 1 | Queue-control write strobe |
| fcr_wdata | input | 8 | Queue-control write data |
| rx_stb | input | 1 | Character-received strobe from the deserializer |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Break tag of the received character |
| rx_frm | input | 1 | Framing tag of the received character |
| rx_par | input | 1 | Parity tag of the received character |
| rd_data_stb | input | 1 | Host read of the data register (pops head) |
| rd_lsr_stb | input | 1 | Host read of the line status byte |
| rd_data | output | 8 | Head character (0 when empty) |
| lsr | output | 8 | Line status bits owned by the receive side |
| rx_level | output | 5 | Characters currently held |
| trig_hit | output | 1 | Count has reached the trigger level |
| fifo_en | output | 1 | Queue mode selected |
| dma_mode | output | 1 | DMA mode field |
| trig_sel | output | 2 | Trigger code field |
| tx_fifo_clr | output | 1 | One-cycle flush pulse to the transmit queue |

## Verification
The bench builds the block with the default depth of 16 and trigger levels 1, 4, 8 and 14. At that depth, sixteen pushes fill the store and the seventeenth reaches the overrun path, including its collision with a same-cycle pop. Level 14 sits two below full, so the trigger and full boundaries can be told apart in a short run. The random phase issues rare control writes so that the store still fills. It therefore mixes mode switches, flush/arrival collisions and status reads on tagged heads in both modes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;

    // queue-control bit positions (decoded by the host interface)
    localparam int FC_EN    = 0;
    localparam int FC_RXCLR = 1;
    localparam int FC_TXCLR = 2;
    localparam int FC_DMA   = 3;
    localparam int FC_TRG   = 6;

    // line status bit positions
    localparam int LS_DR   = 0;
    localparam int LS_OVR  = 1;
    localparam int LS_PAR  = 2;
    localparam int LS_FRM  = 3;
    localparam int LS_BRK  = 4;
    localparam int LS_QERR = 7;

    typedef enum logic [0:0] {
        MODE_CHAR = 1'b0,
        MODE_FIFO = 1'b1
    } rxq_mode_e;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rxq_slot_t;
endpackage

// File: rtl/rxq_fcr.sv
module rxq_fcr
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic       dma_mode,
    output logic [1:0] trig_sel,
    output logic       flush_rx,
    output logic       tx_clr
);
    rxq_mode_e  state_q, state_d;
    logic       dma_q;
    logic [1:0] trg_q;
    logic       txclr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CHAR: if (we && wdata[FC_EN])  state_d = MODE_FIFO;
            MODE_FIFO: if (we && !wdata[FC_EN]) state_d = MODE_CHAR;
            default:   state_d = MODE_CHAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_CHAR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_q   <= 1'b0;
            trg_q   <= 2'b00;
            txclr_q <= 1'b0;
        end else begin
            if (we && wdata[FC_EN]) begin
                dma_q <= wdata[FC_DMA];
                trg_q <= wdata[FC_TRG+1:FC_TRG];
            end
            txclr_q <= we && (!wdata[FC_EN] || wdata[FC_TXCLR] || state_q == MODE_CHAR);
        end
    end

    always_comb begin
        fifo_en  = (state_q == MODE_FIFO);
        dma_mode = dma_q;
        trig_sel = trg_q;
        tx_clr   = txclr_q;
        flush_rx = we && (!wdata[FC_EN] || wdata[FC_RXCLR] || state_q == MODE_CHAR);
    end

    // R2
    leave_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[FC_EN]) |=> !fifo_en);
    // R2
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && wdata[FC_EN]) |=> ($stable(dma_mode) && $stable(trig_sel)));
    // R3
    txclr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> !tx_clr);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          flush,
    input  logic          push_req,
    input  rxq_slot_t     push_slot,
    input  logic          pop_req,
    input  logic          tag_clr_req,
    output rxq_slot_t     head,
    output logic [CW-1:0] count,
    output logic          drop,
    output logic          any_tag
);
    logic [AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q, tag_cnt_q, cap;
    logic          full, has, do_push, do_pop, do_clr, head_tagged, new_tagged;
    rxq_slot_t     mem_q [DEPTH];

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        cap         = fifo_en ? CW'(DEPTH) : CW'(1);
        full        = (cnt_q == cap);
        has         = (cnt_q != '0);
        do_push     = push_req && !full && !flush;
        drop        = push_req && full && !flush;
        do_pop      = pop_req && has && !flush;
        do_clr      = tag_clr_req && has && !pop_req && !flush;
        head        = mem_q[rd_ptr_q];
        head_tagged = has && (head.brk || head.frm || head.par);
        new_tagged  = push_slot.brk || push_slot.frm || push_slot.par;
        count       = cnt_q;
        any_tag     = (tag_cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q  <= '0;
            wr_ptr_q  <= '0;
            cnt_q     <= '0;
            tag_cnt_q <= '0;
        end else if (flush) begin
            rd_ptr_q  <= '0;
            wr_ptr_q  <= '0;
            cnt_q     <= '0;
            tag_cnt_q <= '0;
        end else begin
            if (do_push) wr_ptr_q <= step_ptr(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= step_ptr(rd_ptr_q);
            cnt_q     <= cnt_q + CW'(do_push) - CW'(do_pop);
            tag_cnt_q <= tag_cnt_q + CW'(do_push && new_tagged)
                                   - CW'(head_tagged && (do_pop || do_clr));
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr_q == AW'(g)) begin
                mem_q[g] <= push_slot;
            end else if (do_clr && rd_ptr_q == AW'(g)) begin
                mem_q[g].brk <= 1'b0;
                mem_q[g].frm <= 1'b0;
                mem_q[g].par <= 1'b0;
            end
        end
    end

    // R4
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cap);
    // R12
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));
    // R9
    tag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_cnt_q <= cnt_q);
endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
    import rxq_pkg::*;
#(
    parameter int CW    = 5,
    parameter int LVL_0 = 1,
    parameter int LVL_1 = 4,
    parameter int LVL_2 = 8,
    parameter int LVL_3 = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] count,
    input  rxq_slot_t     head,
    input  logic          any_tag,
    input  logic          drop,
    input  logic          lsr_rd,
    output logic [7:0]    lsr,
    output logic          trig_hit
);
    logic          ovr_q;
    logic [CW-1:0] lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ovr_q <= 1'b0;
        else if (drop)   ovr_q <= 1'b1;
        else if (lsr_rd) ovr_q <= 1'b0;
    end

    always_comb begin
        unique case (trig_sel)
            2'b00:   lvl = CW'(LVL_0);
            2'b01:   lvl = CW'(LVL_1);
            2'b10:   lvl = CW'(LVL_2);
            default: lvl = CW'(LVL_3);
        endcase
        if (!fifo_en) lvl = CW'(1);
        trig_hit = (count >= lvl);
    end

    always_comb begin
        lsr          = '0;
        lsr[LS_DR]   = (count != '0);
        lsr[LS_OVR]  = ovr_q;
        if (count != '0) begin
            lsr[LS_PAR] = head.par;
            lsr[LS_FRM] = head.frm;
            lsr[LS_BRK] = head.brk;
        end
        lsr[LS_QERR] = fifo_en && any_tag;
    end

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> lsr[LS_OVR]);
    // R8
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !drop) |=> !lsr[LS_OVR]);
    // R9
    qerr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !lsr[LS_QERR]);
    // R10
    trig_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> lsr[LS_DR]);
endmodule

// File: rtl/rx_fifo_tagged.sv
module rx_fifo_tagged
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_0 = 1,
    parameter int LVL_1 = 4,
    parameter int LVL_2 = 8,
    parameter int LVL_3 = 14,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcr_we,
    input  logic [7:0]        fcr_wdata,
    input  logic              rx_stb,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_brk,
    input  logic              rx_frm,
    input  logic              rx_par,
    input  logic              rd_data_stb,
    input  logic              rd_lsr_stb,
    output logic [CHAR_W-1:0] rd_data,
    output logic [7:0]        lsr,
    output logic [CW-1:0]     rx_level,
    output logic              trig_hit,
    output logic              fifo_en,
    output logic              dma_mode,
    output logic [1:0]        trig_sel,
    output logic              tx_fifo_clr
);
    logic      flush_rx, drop, any_tag;
    rxq_slot_t in_slot, head;

    always_comb begin
        in_slot.brk  = rx_brk;
        in_slot.frm  = rx_frm;
        in_slot.par  = rx_par;
        in_slot.data = rx_char;
    end

    rxq_fcr u_fcr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (fcr_we),
        .wdata    (fcr_wdata),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .trig_sel (trig_sel),
        .flush_rx (flush_rx),
        .tx_clr   (tx_fifo_clr)
    );

    rxq_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (fifo_en),
        .flush       (flush_rx),
        .push_req    (rx_stb),
        .push_slot   (in_slot),
        .pop_req     (rd_data_stb),
        .tag_clr_req (rd_lsr_stb),
        .head        (head),
        .count       (rx_level),
        .drop        (drop),
        .any_tag     (any_tag)
    );

    rxq_lsr #(.CW(CW), .LVL_0(LVL_0), .LVL_1(LVL_1), .LVL_2(LVL_2), .LVL_3(LVL_3)) u_lsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .count    (rx_level),
        .head     (head),
        .any_tag  (any_tag),
        .drop     (drop),
        .lsr_rd   (rd_lsr_stb),
        .lsr      (lsr),
        .trig_hit (trig_hit)
    );

    always_comb rd_data = (rx_level != '0) ? head.data : '0;

    // R11
    tx_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6:5] == 2'b00);
endmodule

// File: tb/rx_fifo_tagged_tb.sv
`timescale 1ns/1ps
module rx_fifo_tagged_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcr_we = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic       rx_stb = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_brk = 1'b0, rx_frm = 1'b0, rx_par = 1'b0;
    logic       rd_data_stb = 1'b0, rd_lsr_stb = 1'b0;
    logic [7:0] rd_data, lsr;
    logic [4:0] rx_level;
    logic       trig_hit, fifo_en, dma_mode, tx_fifo_clr;
    logic [1:0] trig_sel;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    // bench model
    logic [10:0] mq[$];
    bit          m_en = 0, m_dma = 0, m_ovr = 0, m_txc = 0;
    logic [1:0]  m_trg = 0;

    always #4 clk = ~clk;

    rx_fifo_tagged dut_i (
        .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .rx_stb(rx_stb), .rx_char(rx_char), .rx_brk(rx_brk), .rx_frm(rx_frm),
        .rx_par(rx_par), .rd_data_stb(rd_data_stb), .rd_lsr_stb(rd_lsr_stb),
        .rd_data(rd_data), .lsr(lsr), .rx_level(rx_level), .trig_hit(trig_hit),
        .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_sel(trig_sel),
        .tx_fifo_clr(tx_fifo_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lvl_of(input logic [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit any_tagged();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_edge();
        bit flush, full, pop, clr, drop, push;
        int cap;
        cap   = m_en ? 16 : 1;
        flush = fcr_we && (!fcr_wdata[0] || fcr_wdata[1] || !m_en);
        full  = (mq.size() == cap);
        pop   = rd_data_stb && mq.size() > 0 && !flush;
        clr   = rd_lsr_stb && mq.size() > 0 && !rd_data_stb && !flush;
        drop  = rx_stb && full && !flush;
        push  = rx_stb && !full && !flush;
        m_txc = fcr_we && (!fcr_wdata[0] || fcr_wdata[2] || !m_en);
        if (flush) mq.delete();
        else begin
            if (pop) void'(mq.pop_front());
            else if (clr) mq[0][10:8] = 3'b000;
            if (push) mq.push_back({rx_brk, rx_frm, rx_par, rx_char});
        end
        if (drop) m_ovr = 1;
        else if (rd_lsr_stb) m_ovr = 0;
        if (fcr_we) begin
            m_en = fcr_wdata[0];
            if (fcr_wdata[0]) begin
                m_dma = fcr_wdata[3];
                m_trg = fcr_wdata[7:6];
            end
        end
    endtask

    task automatic compare();
        int n;
        logic [2:0] tg;
        n  = mq.size();
        tg = (n > 0) ? mq[0][10:8] : 3'b000;
        chk(lsr[0] == (n > 0), "R6 data ready", int'(lsr[0]), int'(n > 0));
        chk(lsr[1] == m_ovr, "R5 overrun", int'(lsr[1]), int'(m_ovr));
        chk(lsr[4:2] == tg, "R7 head tags", int'(lsr[4:2]), int'(tg));
        chk(lsr[6:5] == 2'b00, "R11 tx bits", int'(lsr[6:5]), 0);
        chk(lsr[7] == (m_en && any_tagged()), "R9 queue error", int'(lsr[7]), int'(m_en && any_tagged()));
        chk(int'(rx_level) == n, "R4 count", int'(rx_level), n);
        if (n > 0) chk(rd_data == mq[0][7:0], "R4 head data", int'(rd_data), int'(mq[0][7:0]));
        chk(trig_hit == (n >= (m_en ? lvl_of(m_trg) : 1)), "R10 trigger", int'(trig_hit),
            int'(n >= (m_en ? lvl_of(m_trg) : 1)));
        chk({fifo_en, dma_mode, trig_sel} == {m_en, m_dma, m_trg}, "R2 control fields",
            int'({fifo_en, dma_mode, trig_sel}), int'({m_en, m_dma, m_trg}));
        chk(tx_fifo_clr == m_txc, "R3 tx flush pulse", int'(tx_fifo_clr), int'(m_txc));
    endtask

    // one cycle: drive after negedge, model at posedge, compare at next negedge
    task automatic step(input bit we, input logic [7:0] w, input bit rv, input logic [7:0] ch,
                        input logic [2:0] tags, input bit rd, input bit rl);
        fcr_we = we; fcr_wdata = w; rx_stb = rv; rx_char = ch;
        {rx_brk, rx_frm, rx_par} = tags; rd_data_stb = rd; rd_lsr_stb = rl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 8'h00, 3'b000, 0, 0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(lsr == 8'h00, "R1 lsr", int'(lsr), 0);
        chk(rx_level == 0 && !fifo_en && !dma_mode && trig_sel == 0 && !tx_fifo_clr,
            "R1 fields", int'({rx_level, fifo_en, dma_mode, trig_sel, tx_fifo_clr}), 0);
        compare();

        // character mode: capacity 1, overrun, status read clears
        step(0, 0, 1, 8'h41, 3'b001, 0, 0);
        step(0, 0, 1, 8'h42, 3'b000, 0, 0);
        chk(lsr[1] == 1'b1, "R5 char-mode overrun", int'(lsr[1]), 1);
        step(0, 0, 0, 0, 3'b000, 0, 1);
        chk(lsr[2:1] == 2'b00, "R8 status read clears", int'(lsr[2:1]), 0);
        chk(rd_data == 8'h41, "R4 char kept", int'(rd_data), 8'h41);

        // enter queue mode, dma 1, trigger code 11: flushes
        step(1, 8'hC9, 0, 0, 3'b000, 0, 0);
        chk(rx_level == 0 && fifo_en, "R3 enter flush", int'(rx_level), 0);
        for (int i = 0; i < 16; i++) begin
            logic [2:0] t;
            t = (i == 3) ? 3'b100 : (i == 10) ? 3'b010 : 3'b000;
            step(0, 0, 1, 8'(8'h10 + i), t, 0, 0);
            if (i == 12) chk(trig_hit == 1'b0, "R10 below 14", int'(trig_hit), 0);
            if (i == 13) chk(trig_hit == 1'b1, "R10 at 14", int'(trig_hit), 1);
        end
        chk(lsr[7] == 1'b1 && lsr[4:2] == 3'b000, "R9 hidden tags", int'(lsr), 8'h81);
        // 17th with same-cycle pop: still dropped
        step(0, 0, 1, 8'hEE, 3'b000, 1, 0);
        chk(lsr[1] == 1'b1 && rx_level == 15, "R5 full with pop", int'(rx_level), 15);
        for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 3'b000, 1, 0);
        chk(lsr[4] == 1'b1, "R7 break at head", int'(lsr[4]), 1);
        step(0, 0, 0, 0, 3'b000, 0, 1);
        chk(lsr[4] == 1'b0 && lsr[7] == 1'b1, "R8 head tag cleared", int'(lsr), 8'h81);

        // bit0 = 0 with other bits set: fields ignored, store emptied
        step(1, 8'h0E, 0, 0, 3'b000, 0, 0);
        chk(dma_mode == 1'b1 && trig_sel == 2'b11 && rx_level == 0, "R2 ignored bits",
            int'({dma_mode, trig_sel}), 7);
        chk(tx_fifo_clr == 1'b1, "R3 tx pulse", int'(tx_fifo_clr), 1);
        idle();
        chk(tx_fifo_clr == 1'b0, "R3 pulse ends", int'(tx_fifo_clr), 0);

        // flush vs arrival
        step(1, 8'h01, 0, 0, 3'b000, 0, 0);
        step(0, 0, 1, 8'h55, 3'b000, 0, 0);
        step(1, 8'h03, 1, 8'h66, 3'b111, 0, 1);
        chk(rx_level == 0 && lsr[1] == 1'b0, "R12 flush wins", int'(lsr), 0);

        // trigger codes
        for (int c = 0; c < 4; c++) begin
            step(1, 8'({c[1:0], 6'b000011}), 0, 0, 3'b000, 0, 0);
            for (int k = 0; k < lvl_of(2'(c)); k++) step(0, 0, 1, 8'(k), 3'b000, 0, 0);
            chk(trig_hit == 1'b1, "R10 level reached", int'(trig_hit), 1);
        end

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit we;
            logic [7:0] w;
            we = ($urandom % 100) < 2;
            w  = 8'($urandom);
            if (($urandom % 4) != 0) w[0] = 1'b1;
            if (($urandom % 3) != 0) w[1] = 1'b0;
            step(we, w, ($urandom % 100) < 50, 8'($urandom),
                 (($urandom % 4) == 0) ? 3'($urandom) : 3'b000,
                 ($urandom % 100) < 35, ($urandom % 100) < 15);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule